// File: doc/BRIEF.md
# Script Instruction Illegal-Operation Checker

This block runs beside the fetch and decode stage of a small DMA sequencer that executes a script of instructions. Each fetched instruction is presented to the checker with a one-cycle strobe. The checker sees four fields: the command byte, the 24-bit count word, a first operand address and a second operand address. It also receives the current bus role, which is initiator or target. The checker judges the instruction against rules that depend on its class. It does not execute anything.

When an instruction breaks any rule, the checker sets a sticky error flag on the next clock edge and fires a one-cycle interrupt pulse. It also drives a halt output that tracks the flag, which stops the sequencer until the host writes a one to the clear input. The class comes from command bits 7:6. Value 00 is a block move and 01 is unassigned; neither is checked. Value 10 is transfer control. Value 11 is split by command bit 4: bit 4 set means load/store, bit 4 clear means memory move.

For load/store, the count word carries the register address in bits 23:16 and the byte count in bits 15:0. The first operand is the memory address. For memory move, the first operand is the source and the second is the destination. The device's own address space is 16 KiB at 0x4000_0000. Its RAM sub-window sits at 0x4000_1000 (4 KiB) and its ROM sub-window at 0x4000_2000 (8 KiB). The remainder of that space is the operating-register window.

Top module: `script_op_checker`

## Requirements
- R1: After reset, illegal_flag, irq_pulse and seq_halt are all 0.
- R2: A transfer-control instruction (command bits 7:6 = 10) with count-word bit 22 set is illegal; with bit 22 clear it is legal.
- R3: A transfer-control instruction with count-word bit 16 set is illegal when target_mode is 1 and legal when target_mode is 0.
- R4: A load/store instruction (command bits 7:6 = 11, bit 4 = 1) is illegal when its memory address lies in the device space 0x4000_0000..0x4000_3FFF but outside both the RAM window (0x4000_1000..0x4000_1FFF) and the ROM window (0x4000_2000..0x4000_3FFF). Addresses in RAM, ROM or outside the device space are legal.
- R5: A load/store instruction is illegal when bits 1:0 of the register address (count-word bits 17:16) differ from bits 1:0 of the memory address.
- R6: A load/store instruction is illegal when command bit 5 is 0, or when command bit 3 or bit 2 is 1. Bits 1:0 are free.
- R7: A load/store instruction is illegal when its byte count (count-word bits 15:0) is 0 or greater than 4.
- R8: A load/store instruction is illegal when memory-address bits 1:0 plus the byte count exceed 4, because the access would cross a dword boundary.
- R9: A memory-move instruction (command bits 7:6 = 11, bit 4 = 0) is illegal when any of the reserved command bits 5, 3, 2 or 1 is set. Bit 0 is free.
- R10: A memory-move instruction is illegal when bits 1:0 of the source and destination addresses differ.
- R11: illegal_flag is set on the clock edge that samples an illegal instruction with instr_valid high. It then holds until a cycle with err_clr high and no new illegal instruction, after which it is 0. A new illegal instruction wins over a simultaneous clear. seq_halt always equals illegal_flag.
- R12: irq_pulse is high for exactly the one cycle after each sampled illegal instruction.
- R13: Block-move instructions (bits 7:6 = 00), class 01 instructions, and any fields presented while instr_valid is 0 never set the flag or the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | One-cycle strobe marking a fetched instruction |
| cmd | input | 8 | Command byte |
| byte_cnt | input | 24 | Count word (register address and byte count for load/store; option bits for transfer control) |
| addr_a | input | 32 | First operand address (memory address or move source) |
| addr_b | input | 32 | Second operand address (move destination) |
| target_mode | input | 1 | 1 when the device acts as target, 0 as initiator |
| err_clr | input | 1 | Host write-one-to-clear of the error flag |
| illegal_flag | output | 1 | Sticky illegal-instruction error |
| irq_pulse | output | 1 | One-cycle interrupt pulse per illegal instruction |
| seq_halt | output | 1 | Sequencer halt, follows the flag |

## Verification
The hardest case to reach is a load/store that breaks exactly one rule while passing all the others. Several rules share the same fields: the lane bits feed both the alignment rule and the boundary rule, and the count feeds both the range rule and the crossing rule. The stimulus therefore starts from a legal base instruction: register lane equal to address lane, count within the lane's remaining room, and an address outside the device space. Each case moves one field at a time, together with a legal twin. The flag's priority of set over clear is reached by raising err_clr in the same cycle that a second illegal instruction is strobed while the flag is already up.

// File: rtl/script_op_checker_pkg.sv
package script_op_checker_pkg;

  typedef enum logic [1:0] {
    CLS_BLOCK  = 2'b00,
    CLS_UNUSED = 2'b01,
    CLS_XFER   = 2'b10,
    CLS_MEMREG = 2'b11
  } instr_class_e;

  localparam int CMD_W         = 8;
  localparam int CMD_SUBSEL    = 4;   // splits class 11: 1 load/store, 0 memory move
  localparam int TC_RSVD_BIT   = 22;
  localparam int TC_WAIT_BIT   = 16;
  localparam int LS_MUST_SET   = 5;
  localparam int LS_CLR_HI     = 3;
  localparam int LS_CLR_LO     = 2;

  localparam int LS_NRULE = 5;
  localparam int MM_NRULE = 2;
  localparam int TC_NRULE = 2;

endpackage

// File: rtl/xfer_rule_chk.sv
module xfer_rule_chk
  import script_op_checker_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic [CNT_W-1:0]    cnt_word,
  input  logic                target_mode,
  output logic [TC_NRULE-1:0] viol
);
  always_comb begin
    viol    = '0;
    viol[0] = cnt_word[TC_RSVD_BIT];
    viol[1] = cnt_word[TC_WAIT_BIT] & target_mode;
  end
endmodule

// File: rtl/ldst_rule_chk.sv
module ldst_rule_chk
  import script_op_checker_pkg::*;
#(
  parameter int              ADDR_W     = 32,
  parameter int              CNT_W      = 24,
  parameter int              REG_ADDR_W = 8,
  parameter int              LS_CNT_W   = 16,
  parameter int              DATA_BYTES = 4,
  parameter logic [ADDR_W-1:0] DEV_BASE = 32'h4000_0000,
  parameter int              DEV_SPAN   = 16384,
  parameter logic [ADDR_W-1:0] RAM_BASE = 32'h4000_1000,
  parameter int              RAM_SPAN   = 4096,
  parameter logic [ADDR_W-1:0] ROM_BASE = 32'h4000_2000,
  parameter int              ROM_SPAN   = 8192
) (
  input  logic [CMD_W-1:0]    cmd,
  input  logic [CNT_W-1:0]    cnt_word,
  input  logic [ADDR_W-1:0]   mem_addr,
  output logic [LS_NRULE-1:0] viol
);
  localparam int LANE_W = $clog2(DATA_BYTES);
  localparam int SUM_W  = LS_CNT_W + 1;

  function automatic logic hit(input logic [ADDR_W-1:0] a,
                               input logic [ADDR_W-1:0] base,
                               input int span);
    logic [ADDR_W-1:0] mask;
    mask = ~(ADDR_W'(span) - 1'b1);
    return ((a ^ base) & mask) == '0;
  endfunction

  logic [REG_ADDR_W-1:0] reg_addr;
  logic [LS_CNT_W-1:0]   count;
  logic [SUM_W-1:0]      reach;
  logic                  in_dev, in_ram, in_rom;

  always_comb begin
    reg_addr = cnt_word[CNT_W-1 -: REG_ADDR_W];
    count    = cnt_word[LS_CNT_W-1:0];
    in_dev   = hit(mem_addr, DEV_BASE, DEV_SPAN);
    in_ram   = hit(mem_addr, RAM_BASE, RAM_SPAN);
    in_rom   = hit(mem_addr, ROM_BASE, ROM_SPAN);
    reach    = SUM_W'(count) + SUM_W'(mem_addr[LANE_W-1:0]);

    viol    = '0;
    viol[0] = in_dev & ~in_ram & ~in_rom;
    viol[1] = reg_addr[LANE_W-1:0] != mem_addr[LANE_W-1:0];
    viol[2] = ~cmd[LS_MUST_SET] | cmd[LS_CLR_HI] | cmd[LS_CLR_LO];
    viol[3] = (count == '0) || (count > LS_CNT_W'(DATA_BYTES));
    viol[4] = reach > SUM_W'(DATA_BYTES);
  end
endmodule

// File: rtl/mmove_rule_chk.sv
module mmove_rule_chk
  import script_op_checker_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_BYTES = 4,
  parameter logic [CMD_W-1:0] RSVD_MASK = 8'b0010_1110
) (
  input  logic [CMD_W-1:0]    cmd,
  input  logic [ADDR_W-1:0]   src_addr,
  input  logic [ADDR_W-1:0]   dst_addr,
  output logic [MM_NRULE-1:0] viol
);
  localparam int LANE_W = $clog2(DATA_BYTES);

  always_comb begin
    viol    = '0;
    viol[0] = |(cmd & RSVD_MASK);
    viol[1] = src_addr[LANE_W-1:0] != dst_addr[LANE_W-1:0];
  end
endmodule

// File: rtl/err_latch.sv
module err_latch (
  input  logic clk,
  input  logic rst,
  input  logic hit_valid,
  input  logic hit_illegal,
  input  logic clr,
  output logic flag,
  output logic pulse,
  output logic halt
);
  logic set_now;
  assign set_now = hit_valid & hit_illegal;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag  <= 1'b0;
      pulse <= 1'b0;
      halt  <= 1'b0;
    end else begin
      pulse <= set_now;
      if (set_now) begin
        flag <= 1'b1;
        halt <= 1'b1;
      end else if (clr) begin
        flag <= 1'b0;
        halt <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/script_op_checker.sv
module script_op_checker
  import script_op_checker_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int CNT_W      = 24,
  parameter int REG_ADDR_W = 8,
  parameter int LS_CNT_W   = 16,
  parameter int DATA_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              instr_valid,
  input  logic [7:0]        cmd,
  input  logic [CNT_W-1:0]  byte_cnt,
  input  logic [ADDR_W-1:0] addr_a,
  input  logic [ADDR_W-1:0] addr_b,
  input  logic              target_mode,
  input  logic              err_clr,
  output logic              illegal_flag,
  output logic              irq_pulse,
  output logic              seq_halt
);
  instr_class_e        cls;
  logic                is_tc, is_ls, is_mm, illegal;
  logic [TC_NRULE-1:0] tc_v;
  logic [LS_NRULE-1:0] ls_v;
  logic [MM_NRULE-1:0] mm_v;

  always_comb begin
    cls   = instr_class_e'(cmd[7:6]);
    is_tc = (cls == CLS_XFER);
    is_ls = (cls == CLS_MEMREG) &  cmd[CMD_SUBSEL];
    is_mm = (cls == CLS_MEMREG) & ~cmd[CMD_SUBSEL];
  end

  xfer_rule_chk #(.CNT_W(CNT_W)) u_tc (
    .cnt_word    (byte_cnt),
    .target_mode (target_mode),
    .viol        (tc_v)
  );

  ldst_rule_chk #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .REG_ADDR_W(REG_ADDR_W),
    .LS_CNT_W(LS_CNT_W), .DATA_BYTES(DATA_BYTES)
  ) u_ls (
    .cmd      (cmd),
    .cnt_word (byte_cnt),
    .mem_addr (addr_a),
    .viol     (ls_v)
  );

  mmove_rule_chk #(.ADDR_W(ADDR_W), .DATA_BYTES(DATA_BYTES)) u_mm (
    .cmd      (cmd),
    .src_addr (addr_a),
    .dst_addr (addr_b),
    .viol     (mm_v)
  );

  assign illegal = (is_tc & |tc_v) | (is_ls & |ls_v) | (is_mm & |mm_v);

  err_latch u_err (
    .clk         (clk),
    .rst         (rst),
    .hit_valid   (instr_valid),
    .hit_illegal (illegal),
    .clr         (err_clr),
    .flag        (illegal_flag),
    .pulse       (irq_pulse),
    .halt        (seq_halt)
  );
endmodule

// File: rtl/script_op_checker_sva.sv
module script_op_checker_sva (
  input logic        clk,
  input logic        rst,
  input logic        instr_valid,
  input logic [7:0]  cmd,
  input logic [23:0] byte_cnt,
  input logic [31:0] addr_a,
  input logic [31:0] addr_b,
  input logic        target_mode,
  input logic        err_clr,
  input logic        illegal_flag,
  input logic        irq_pulse,
  input logic        seq_halt
);
  always @(posedge clk) begin
    if (!rst) assert_halt_tracks_flag_R11: assert (seq_halt == illegal_flag);
  end

  assert_tc_rsvd_R2: assert property (@(posedge clk) disable iff (rst)
    (instr_valid && cmd[7:6] == 2'b10 && byte_cnt[22]) |=> (illegal_flag && irq_pulse));

  assert_tc_wait_target_R3: assert property (@(posedge clk) disable iff (rst)
    (instr_valid && cmd[7:6] == 2'b10 && byte_cnt[16] && target_mode) |=> irq_pulse);

  assert_ls_lane_R5: assert property (@(posedge clk) disable iff (rst)
    (instr_valid && cmd[7:6] == 2'b11 && cmd[4] && byte_cnt[17:16] != addr_a[1:0]) |=> irq_pulse);

  assert_ls_count_zero_R7: assert property (@(posedge clk) disable iff (rst)
    (instr_valid && cmd[7:6] == 2'b11 && cmd[4] && byte_cnt[15:0] == 16'd0) |=> irq_pulse);

  assert_mm_lane_R10: assert property (@(posedge clk) disable iff (rst)
    (instr_valid && cmd[7:6] == 2'b11 && !cmd[4] && addr_a[1:0] != addr_b[1:0]) |=> irq_pulse);

  assert_sticky_R11: assert property (@(posedge clk) disable iff (rst)
    (illegal_flag && !err_clr) |=> illegal_flag);

  assert_clear_R11: assert property (@(posedge clk) disable iff (rst)
    (err_clr && !instr_valid) |=> !illegal_flag);

  assert_pulse_needs_strobe_R12: assert property (@(posedge clk) disable iff (rst)
    !instr_valid |=> !irq_pulse);

  assert_pulse_sets_flag_R12: assert property (@(posedge clk) disable iff (rst)
    irq_pulse |-> illegal_flag);

  assert_block_move_quiet_R13: assert property (@(posedge clk) disable iff (rst)
    (instr_valid && !cmd[7]) |=> !irq_pulse);
endmodule

bind script_op_checker script_op_checker_sva u_sva (.*);

// File: tb/tb_script_op_checker.sv
`timescale 1ns/1ps
module tb_script_op_checker;
  logic        clk = 1'b0;
  logic        rst;
  logic        instr_valid;
  logic [7:0]  cmd;
  logic [23:0] byte_cnt;
  logic [31:0] addr_a, addr_b;
  logic        target_mode, err_clr;
  logic        illegal_flag, irq_pulse, seq_halt;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  script_op_checker dut (
    .clk(clk), .rst(rst), .instr_valid(instr_valid), .cmd(cmd),
    .byte_cnt(byte_cnt), .addr_a(addr_a), .addr_b(addr_b),
    .target_mode(target_mode), .err_clr(err_clr),
    .illegal_flag(illegal_flag), .irq_pulse(irq_pulse), .seq_halt(seq_halt)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  // Called at a negedge with the flag clear; returns at a negedge with the flag clear.
  task automatic run_case(input string req, input logic [7:0] c, input logic [23:0] n,
                          input logic [31:0] a, input logic [31:0] b,
                          input logic tgt, input logic exp_bad);
    cmd = c; byte_cnt = n; addr_a = a; addr_b = b; target_mode = tgt;
    instr_valid = 1'b1;
    @(negedge clk);
    instr_valid = 1'b0;
    chk(req, "flag after strobe", illegal_flag, exp_bad);
    chk(req, "irq after strobe", irq_pulse, exp_bad);
    chk(req, "halt after strobe", seq_halt, exp_bad);
    @(negedge clk);
    chk("R12", "irq one cycle only", irq_pulse, 1'b0);
    chk("R11", "flag held", illegal_flag, exp_bad);
    err_clr = 1'b1;
    @(negedge clk);
    err_clr = 1'b0;
    chk("R11", "flag cleared", illegal_flag, 1'b0);
    target_mode = 1'b0;
  endtask

  localparam logic [7:0] TC = 8'h80, LS = 8'hF0, MM = 8'hC0;
  localparam logic [31:0] OUTA = 32'h0000_1000;

  task automatic t_reset();
    chk("R1", "flag after reset", illegal_flag, 1'b0);
    chk("R1", "irq after reset", irq_pulse, 1'b0);
    chk("R1", "halt after reset", seq_halt, 1'b0);
  endtask

  task automatic t_xfer();
    run_case("R2", TC, 24'h40_0000, 0, 0, 1'b0, 1'b1);
    run_case("R2", TC, 24'h00_0000, 0, 0, 1'b0, 1'b0);
    run_case("R3", TC, 24'h01_0000, 0, 0, 1'b1, 1'b1);
    run_case("R3", TC, 24'h01_0000, 0, 0, 1'b0, 1'b0);
  endtask

  task automatic t_ldst();
    run_case("R4", LS, 24'h10_0004, OUTA, 0, 1'b0, 1'b0);
    run_case("R4", LS, 24'h10_0004, 32'h4000_0010, 0, 1'b0, 1'b1);
    run_case("R4", LS, 24'h10_0004, 32'h4000_1010, 0, 1'b0, 1'b0);
    run_case("R4", LS, 24'h10_0004, 32'h4000_2010, 0, 1'b0, 1'b0);
    run_case("R4", LS, 24'h10_0004, 32'h4000_4000, 0, 1'b0, 1'b0);
    run_case("R5", LS, 24'h11_0001, OUTA, 0, 1'b0, 1'b1);
    run_case("R5", LS, 24'h11_0001, OUTA + 1, 0, 1'b0, 1'b0);
    run_case("R6", 8'hD0, 24'h10_0004, OUTA, 0, 1'b0, 1'b1);
    run_case("R6", 8'hF8, 24'h10_0004, OUTA, 0, 1'b0, 1'b1);
    run_case("R6", 8'hF4, 24'h10_0004, OUTA, 0, 1'b0, 1'b1);
    run_case("R6", 8'hF3, 24'h10_0004, OUTA, 0, 1'b0, 1'b0);
    run_case("R7", LS, 24'h10_0000, OUTA, 0, 1'b0, 1'b1);
    run_case("R7", LS, 24'h10_0005, OUTA, 0, 1'b0, 1'b1);
    run_case("R7", LS, 24'h10_0104, OUTA, 0, 1'b0, 1'b1);
    run_case("R7", LS, 24'h10_0001, OUTA, 0, 1'b0, 1'b0);
    run_case("R8", LS, 24'h12_0003, OUTA + 2, 0, 1'b0, 1'b1);
    run_case("R8", LS, 24'h12_0002, OUTA + 2, 0, 1'b0, 1'b0);
    run_case("R8", LS, 24'h13_0002, OUTA + 3, 0, 1'b0, 1'b1);
    run_case("R8", LS, 24'h13_0001, OUTA + 3, 0, 1'b0, 1'b0);
  endtask

  task automatic t_mmove();
    run_case("R9",  MM,    0, 32'h100, 32'h200, 1'b0, 1'b0);
    run_case("R9",  8'hC2, 0, 32'h100, 32'h200, 1'b0, 1'b1);
    run_case("R9",  8'hE0, 0, 32'h100, 32'h200, 1'b0, 1'b1);
    run_case("R9",  8'hC8, 0, 32'h100, 32'h200, 1'b0, 1'b1);
    run_case("R9",  8'hC1, 0, 32'h100, 32'h200, 1'b0, 1'b0);
    run_case("R10", MM,    0, 32'h101, 32'h202, 1'b0, 1'b1);
    run_case("R10", MM,    0, 32'h103, 32'h203, 1'b0, 1'b0);
  endtask

  task automatic t_quiet();
    run_case("R13", 8'h3F, 24'hFF_FFFF, 32'h4000_0001, 32'h2, 1'b1, 1'b0);
    run_case("R13", 8'h40, 24'hFF_0000, 32'h4000_0001, 32'h2, 1'b1, 1'b0);
    cmd = 8'hC2; byte_cnt = 24'h40_0000; addr_a = 32'h101; addr_b = 32'h202;
    instr_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk("R13", "flag with no strobe", illegal_flag, 1'b0);
    chk("R13", "irq with no strobe", irq_pulse, 1'b0);
  endtask

  task automatic t_sticky_and_priority();
    cmd = TC; byte_cnt = 24'h40_0000; instr_valid = 1'b1;
    @(negedge clk);
    instr_valid = 1'b0;
    repeat (5) @(negedge clk);
    chk("R11", "flag sticky over idle", illegal_flag, 1'b1);
    chk("R11", "halt sticky over idle", seq_halt, 1'b1);
    err_clr = 1'b1; instr_valid = 1'b1;
    @(negedge clk);
    err_clr = 1'b0; instr_valid = 1'b0;
    chk("R11", "set beats clear", illegal_flag, 1'b1);
    chk("R12", "pulse on second error", irq_pulse, 1'b1);
    err_clr = 1'b1;
    @(negedge clk);
    err_clr = 1'b0;
    chk("R11", "flag cleared after priority", illegal_flag, 1'b0);
    chk("R11", "halt cleared", seq_halt, 1'b0);
    cmd = TC; byte_cnt = 24'h00_0000; err_clr = 1'b0;
    instr_valid = 1'b1;
    @(negedge clk);
    byte_cnt = 24'h40_0000;
    @(negedge clk);
    instr_valid = 1'b0;
    chk("R12", "pulse after second of pair", irq_pulse, 1'b1);
    @(negedge clk);
    chk("R12", "pulse drops", irq_pulse, 1'b0);
    err_clr = 1'b1;
    @(negedge clk);
    err_clr = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    rst = 1'b1; instr_valid = 1'b0; cmd = '0; byte_cnt = '0;
    addr_a = '0; addr_b = '0; target_mode = 1'b0; err_clr = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_xfer();
    t_ldst();
    t_mmove();
    t_quiet();
    t_sticky_and_priority();
    done = 1'b1;
    summary();
    $finish;
  end
endmodule